// File: doc/BRIEF.md
# SD host slot wrapper register block

This block is the register front end of a wrapper that groups one or two SD host slot controllers behind a single 4 KB memory-mapped window. It keeps a bank of 32-bit global registers in the bottom 256 bytes of that window. A few of those registers have fixed non-zero reset values. The rest of the bank is general read/write storage, which includes the words that software uses for write-protect polarity (offset 0xEC) and card-detect (offset 0xF0).

Each slot's capability word and maximum-current word are held here and driven out to the slot controllers. Software can read and overwrite these words through alias offsets in the global map. The block also mirrors each slot's interrupt level into a status word and combines the levels into a single interrupt output.

Each slot's own register window sits at byte offset (n+1)*0x100. This block does not service that window. It raises a per-slot select so that the surrounding fabric can route the access to the slot. Reads return data one cycle after the request. Writes take effect at the clock edge on which they are presented.

Top module: `sdw_wrap_regs`

## Requirements
- R1: After reset, offset 0x00 reads 0x00030000, offset 0x04 reads 0x00000005, and every other global storage word (for example 0x80, 0xEC, 0xF0) reads zero.
- R2: After reset, every slot's capability port and its alias read hold the parameter CAP_RESET, and every maximum-current port holds CUR_RESET (default zero).
- R3: A full write to an alias offset updates that slot's own port on the following cycle. The alias offsets are 0x10 for the slot 0 capability, 0x18 for the slot 0 maximum current, 0x20 for the slot 1 capability and 0x28 for the slot 1 maximum current. The same offset reads the new value back, and no other slot's port changes.
- R4: The remaining offsets below 0x100 are plain read/write storage. This includes 0x00, 0x04, 0xEC and 0xF0.
- R5: Offset 0xFC reads bit n as the level of slot_irq[n] in the request cycle, and its other bits read zero. Writes to 0xFC have no effect on what it reads.
- R6: irq_out is high exactly when at least one slot_irq bit is high.
- R7: Every read request produces exactly one rsp_valid pulse, one cycle later, carrying its data. Writes produce no response.
- R8: Accesses at offsets 0x100 and above change no storage, and such reads return zero.
- R9: An access whose byte enables are not all 4'hF, or whose address bits [1:0] are non-zero, is ignored. It writes nothing, and a read of this kind returns zero.
- R10: slot_sel[n] is high in the cycle of any request whose address lies in [(n+1)*0x100, (n+2)*0x100), and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte address within the window |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| slot_cap | output | NUM_SLOTS x 32 | Capability word per slot |
| slot_cur | output | NUM_SLOTS x 32 | Maximum-current word per slot |
| slot_irq | input | NUM_SLOTS | Interrupt level from each slot |
| irq_out | output | 1 | Combined interrupt |
| slot_sel | output | NUM_SLOTS | Request targets slot n's own window |

## Verification
The bench targets the places where the alias words and the status word meet plain storage. It writes 0xFC and checks that the status still follows the live interrupt levels; a design that stored the status word would read back the written value. It writes one alias offset and checks that the other slot's ports do not change; a design that decoded the slot bit wrongly would corrupt the neighbouring slot. It also sends partial, misaligned and out-of-range writes to offsets that hold known values; a design that did not gate these accesses would overwrite those values or return stale data where zero is expected.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam int DW          = 32;
    localparam int MAX_SLOTS   = 2;
    localparam int BANK_WORDS  = 64;
    localparam int WORD_AW     = $clog2(BANK_WORDS);
    localparam int GLOBAL_BITS = WORD_AW + 2;

    localparam logic [DW-1:0] INFO_RST   = 32'h0003_0000;
    localparam logic [DW-1:0] DEBNC_RST  = 32'h0000_0005;
    localparam logic [WORD_AW-1:0] W_INFO  = 6'h00;
    localparam logic [WORD_AW-1:0] W_DEBNC = 6'h01;
    localparam logic [WORD_AW-1:0] W_IRQ   = 6'h3F;

    typedef enum logic [2:0] {
        HIT_NONE,
        HIT_BANK,
        HIT_CAP,
        HIT_CUR,
        HIT_IRQ
    } hit_e;

    typedef struct packed {
        logic               ok;
        hit_e               hit;
        logic               slot;
        logic [WORD_AW-1:0] word;
    } dec_t;

    function automatic logic [DW-1:0] bank_reset(input int w);
        if (w == int'(W_INFO))  return INFO_RST;
        if (w == int'(W_DEBNC)) return DEBNC_RST;
        return '0;
    endfunction

endpackage

// File: rtl/sdw_decode.sv
module sdw_decode
    import sdw_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_SLOTS = 2
) (
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [3:0]           be,
    output dec_t                 dec,
    output logic [NUM_SLOTS-1:0] win_sel
);

    localparam int HI_W = ADDR_W - GLOBAL_BITS;

    logic [WORD_AW-1:0] w;
    logic               in_global;
    logic               full;
    logic               is_alias;
    logic               slot_bit;

    assign w         = addr[GLOBAL_BITS-1:2];
    assign in_global = (addr[ADDR_W-1:GLOBAL_BITS] == '0);
    assign full      = (be == 4'hF) && (addr[1:0] == 2'b00);
    // alias words 4,6 (slot 0) and 8,10 (slot 1): bits[3:2] in {01,10}, bit0 clear
    assign is_alias  = (w[5:4] == 2'b00) && (w[3] ^ w[2]) && !w[0];
    assign slot_bit  = w[3];

    always_comb begin
        dec      = '0;
        dec.word = w;
        dec.slot = slot_bit;
        dec.ok   = full && in_global;
        if (!dec.ok) begin
            dec.hit = HIT_NONE;
        end else if (w == W_IRQ) begin
            dec.hit = HIT_IRQ;
        end else if (is_alias && (int'(slot_bit) < NUM_SLOTS)) begin
            dec.hit = w[1] ? HIT_CUR : HIT_CAP;
        end else begin
            dec.hit = HIT_BANK;
        end
    end

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_win
        assign win_sel[n] = req_valid &&
                            (addr[ADDR_W-1:GLOBAL_BITS] == HI_W'(n + 1));
    end

endmodule

// File: rtl/sdw_bank.sv
module sdw_bank
    import sdw_pkg::*;
#(
    parameter int WORDS = BANK_WORDS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(WORDS)-1:0] idx,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata
);

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= bank_reset(i);
            end
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/sdw_slot_regs.sv
module sdw_slot_regs
    import sdw_pkg::*;
#(
    parameter int              NUM_SLOTS = 2,
    parameter logic [DW-1:0]   CAP_RESET = 32'h01E8_0080,
    parameter logic [DW-1:0]   CUR_RESET = 32'h0000_0000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we_cap,
    input  logic                          we_cur,
    input  logic                          slot,
    input  logic [DW-1:0]                 wdata,
    output logic [NUM_SLOTS-1:0][DW-1:0]  cap,
    output logic [NUM_SLOTS-1:0][DW-1:0]  cur
);

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
        logic hit;
        assign hit = (slot == 1'(n));

        always_ff @(posedge clk) begin
            if (rst) begin
                cap[n] <= CAP_RESET;
                cur[n] <= CUR_RESET;
            end else begin
                if (we_cap && hit) cap[n] <= wdata;
                if (we_cur && hit) cur[n] <= wdata;
            end
        end
    end

endmodule

// File: rtl/sdw_wrap_regs.sv
module sdw_wrap_regs
    import sdw_pkg::*;
#(
    parameter int            ADDR_W    = 12,
    parameter int            NUM_SLOTS = 2,
    parameter logic [31:0]   CAP_RESET = 32'h01E8_0080,
    parameter logic [31:0]   CUR_RESET = 32'h0000_0000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [3:0]                   req_be,
    input  logic [31:0]                  req_wdata,
    output logic                         rsp_valid,
    output logic [31:0]                  rsp_rdata,
    output logic [NUM_SLOTS-1:0][31:0]   slot_cap,
    output logic [NUM_SLOTS-1:0][31:0]   slot_cur,
    input  logic [NUM_SLOTS-1:0]         slot_irq,
    output logic                         irq_out,
    output logic [NUM_SLOTS-1:0]         slot_sel
);

    dec_t          dec;
    logic          wr_go;
    logic          rd_go;
    logic [DW-1:0] bank_q;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] irq_word;

    sdw_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_dec (
        .req_valid (req_valid),
        .addr      (req_addr),
        .be        (req_be),
        .dec       (dec),
        .win_sel   (slot_sel)
    );

    assign wr_go = req_valid &&  req_write;
    assign rd_go = req_valid && !req_write;

    sdw_bank #(.WORDS(BANK_WORDS)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_go && (dec.hit == HIT_BANK)),
        .idx   (dec.word),
        .wdata (req_wdata),
        .rdata (bank_q)
    );

    sdw_slot_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .CAP_RESET (CAP_RESET),
        .CUR_RESET (CUR_RESET)
    ) u_slots (
        .clk    (clk),
        .rst    (rst),
        .we_cap (wr_go && (dec.hit == HIT_CAP)),
        .we_cur (wr_go && (dec.hit == HIT_CUR)),
        .slot   (dec.slot),
        .wdata  (req_wdata),
        .cap    (slot_cap),
        .cur    (slot_cur)
    );

    assign irq_word = DW'(slot_irq);
    assign irq_out  = |slot_irq;

    always_comb begin
        case (dec.hit)
            HIT_BANK: rd_mux = bank_q;
            HIT_CAP:  rd_mux = slot_cap[int'(dec.slot) % NUM_SLOTS];
            HIT_CUR:  rd_mux = slot_cur[int'(dec.slot) % NUM_SLOTS];
            HIT_IRQ:  rd_mux = irq_word;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_go;
            rsp_rdata <= rd_go ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/sdw_chk.sv
module sdw_chk #(
    parameter int ADDR_W    = 12,
    parameter int NUM_SLOTS = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic                       req_write,
    input logic [ADDR_W-1:0]          req_addr,
    input logic [3:0]                 req_be,
    input logic [31:0]                req_wdata,
    input logic                       rsp_valid,
    input logic [31:0]                rsp_rdata,
    input logic [NUM_SLOTS-1:0][31:0] slot_cap,
    input logic [NUM_SLOTS-1:0][31:0] slot_cur,
    input logic [NUM_SLOTS-1:0]       slot_irq,
    input logic                       irq_out,
    input logic [NUM_SLOTS-1:0]       slot_sel
);

    // R7
    rd_gets_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    // R7
    rsp_only_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && !req_write) && !$past(rst)));

    // R6
    irq_any_chk: assert property (@(posedge clk) disable iff (rst)
        (($countones(slot_irq) != 0) == irq_out));

    // R5
    irq_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_addr == ADDR_W'(12'hFC) && req_be == 4'hF))
        |-> (rsp_rdata == 32'($past(slot_irq))));

    // R3
    cap0_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid && req_write && req_be == 4'hF &&
                             req_addr == ADDR_W'(12'h10)))
        |-> (slot_cap[0] == $past(req_wdata)));

    // R8
    out_of_range_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_addr >= ADDR_W'(12'h100))) |-> (rsp_rdata == 32'h0));

    // R9
    partial_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_be != 4'hF)) |-> (rsp_rdata == 32'h0));

    // R10
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_sel) && (req_valid || (slot_sel == '0)));

endmodule

bind sdw_wrap_regs sdw_chk #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/tb_sdw_wrap_regs.sv
module tb_sdw_wrap_regs;

    localparam logic [31:0] CAPR = 32'h01E8_0080;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [11:0]       req_addr = '0;
    logic [3:0]        req_be = 4'hF;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic [1:0][31:0]  slot_cap;
    logic [1:0][31:0]  slot_cur;
    logic [1:0]        slot_irq = '0;
    logic              irq_out;
    logic [1:0]        slot_sel;

    int errors = 0;
    int checks = 0;
    logic [31:0] expq[$];
    string       tagq[$];

    always #2.5 clk = ~clk;

    sdw_wrap_regs #(.ADDR_W(12), .NUM_SLOTS(2), .CAP_RESET(CAPR)) dut (.*);

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [11:0] a,
                         input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_be = be; req_wdata = d;
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d);
        drive(1'b1, a, 4'hF, d);
    endtask

    task automatic rd(input logic [11:0] a, input logic [3:0] be,
                      input logic [31:0] exp, input string tag);
        drive(1'b0, a, be, 32'h0);
        expq.push_back(exp);
        tagq.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R7 unexpected rsp_valid", rsp_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                chk(rsp_rdata == e, t, rsp_rdata, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(slot_cap[0] == CAPR, "R2 slot_cap0 reset", slot_cap[0], CAPR);
        chk(slot_cap[1] == CAPR, "R2 slot_cap1 reset", slot_cap[1], CAPR);
        chk(slot_cur[1] == 32'h0, "R2 slot_cur1 reset", slot_cur[1], 32'h0);
        chk(irq_out == 1'b0, "R6 irq_out reset", 32'(irq_out), 32'h0);

        rd(12'h000, 4'hF, 32'h0003_0000, "R1 info reset");
        rd(12'h004, 4'hF, 32'h0000_0005, "R1 debounce reset");
        rd(12'h0EC, 4'hF, 32'h0, "R1 wp reset");
        rd(12'h0F0, 4'hF, 32'h0, "R1 cdet reset");
        rd(12'h080, 4'hF, 32'h0, "R1 spare reset");
        rd(12'h010, 4'hF, CAPR, "R2 cap0 alias reset");
        rd(12'h020, 4'hF, CAPR, "R2 cap1 alias reset");
        rd(12'h018, 4'hF, 32'h0, "R2 cur0 alias reset");

        // R3 alias writes
        wr32(12'h010, 32'hA5A5_0001);
        wr32(12'h028, 32'h0000_BEEF);
        idle();
        chk(slot_cap[0] == 32'hA5A5_0001, "R3 cap0 port", slot_cap[0], 32'hA5A5_0001);
        chk(slot_cur[1] == 32'h0000_BEEF, "R3 cur1 port", slot_cur[1], 32'h0000_BEEF);
        chk(slot_cap[1] == CAPR, "R3 cap1 untouched", slot_cap[1], CAPR);
        chk(slot_cur[0] == 32'h0, "R3 cur0 untouched", slot_cur[0], 32'h0);
        rd(12'h010, 4'hF, 32'hA5A5_0001, "R3 cap0 readback");
        rd(12'h028, 4'hF, 32'h0000_BEEF, "R3 cur1 readback");

        // R4 plain storage
        wr32(12'h0EC, 32'h0000_0003);
        wr32(12'h0F0, 32'h1234_5678);
        wr32(12'h040, 32'hDEAD_0040);
        wr32(12'h000, 32'h0F0F_0F0F);
        rd(12'h0EC, 4'hF, 32'h0000_0003, "R4 wp readback");
        rd(12'h0F0, 4'hF, 32'h1234_5678, "R4 cdet readback");
        rd(12'h040, 4'hF, 32'hDEAD_0040, "R4 spare readback");
        rd(12'h000, 4'hF, 32'h0F0F_0F0F, "R4 info readback");

        // R5 / R6 interrupt status
        @(negedge clk); req_valid = 1'b0; slot_irq = 2'b10;
        #1 chk(irq_out == 1'b1, "R6 irq_out slot1", 32'(irq_out), 32'h1);
        rd(12'h0FC, 4'hF, 32'h2, "R5 status slot1");
        wr32(12'h0FC, 32'hFFFF_FFFF);
        rd(12'h0FC, 4'hF, 32'h2, "R5 status after write");
        @(negedge clk); req_valid = 1'b0; slot_irq = 2'b11;
        rd(12'h0FC, 4'hF, 32'h3, "R5 status both");
        @(negedge clk); req_valid = 1'b0; slot_irq = 2'b00;
        #1 chk(irq_out == 1'b0, "R6 irq_out clear", 32'(irq_out), 32'h0);
        rd(12'h0FC, 4'hF, 32'h0, "R5 status clear");

        // R8 out of range, R10 select
        drive(1'b1, 12'h104, 4'hF, 32'hCAFE_0104);
        #1 chk(slot_sel == 2'b01, "R10 sel slot0", 32'(slot_sel), 32'h1);
        drive(1'b1, 12'h204, 4'hF, 32'hCAFE_0204);
        #1 chk(slot_sel == 2'b10, "R10 sel slot1", 32'(slot_sel), 32'h2);
        drive(1'b1, 12'h404, 4'hF, 32'hCAFE_0404);
        #1 chk(slot_sel == 2'b00, "R10 sel none", 32'(slot_sel), 32'h0);
        drive(1'b1, 12'h0F4, 4'hF, 32'h0);
        #1 chk(slot_sel == 2'b00, "R10 sel global", 32'(slot_sel), 32'h0);
        rd(12'h104, 4'hF, 32'h0, "R8 read slot window");
        rd(12'h804, 4'hF, 32'h0, "R8 read high");
        rd(12'h004, 4'hF, 32'h0000_0005, "R8 debounce untouched");

        // R9 partial and misaligned
        drive(1'b1, 12'h0EC, 4'h3, 32'hFFFF_FFFF);
        drive(1'b1, 12'h0EE, 4'hF, 32'hFFFF_FFFF);
        drive(1'b1, 12'h010, 4'h1, 32'h0);
        rd(12'h0EC, 4'hF, 32'h0000_0003, "R9 wp untouched");
        rd(12'h010, 4'hF, 32'hA5A5_0001, "R9 cap0 untouched");
        rd(12'h0F0, 4'h1, 32'h0, "R9 partial read zero");
        rd(12'h0F2, 4'hF, 32'h0, "R9 misaligned read zero");
        idle();
        chk(slot_cap[0] == 32'hA5A5_0001, "R9 cap0 port", slot_cap[0], 32'hA5A5_0001);
        idle();
        idle();
        chk(expq.size() == 0, "R7 responses missing", 32'(expq.size()), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule